// File: doc/BRIEF.md
# Single-Wire Slave Time-Slot Front End

This block sits between a synchronized single-wire bus sample and the bit-level logic of a slave device. It decides when the bus master has opened a new time slot and emits a one-cycle strobe for it. At standard speed a low level must persist for a programmable number of clock cycles before it counts, so short negative noise spikes are discarded. At overdrive speed this filter is bypassed and the first low sample opens the slot.

After every slot the block watches for the line to return high. From that rising edge a hold-off counter runs, and every low sample seen while it runs is ignored, however long it is within the window. A low level that is still present, or that appears, after the window closes goes through the normal falling-edge qualification.

For read slots the slave answers a 0 by pulling the line low from the accepted slot start for a speed-dependent number of cycles. It answers a 1 by leaving the line alone. The bit logic above supplies the answer bit and whether the slot is a read.

Top module: `owire_slot_front`

## Requirements
- R1: While rst_ni is low and on the first cycle after release, slot_start_o is 0, pull_low_o is 0 and line_high_o is 1.
- R2: At standard speed (overdrive_i = 0), a slot is accepted only after FILT_N consecutive low samples of line_i while armed. slot_start_o is 1 for exactly one cycle, in the cycle after the FILT_N-th low sample. A low pulse of FILT_N-1 samples produces no strobe.
- R3: At overdrive speed (overdrive_i = 1), the first low sample while armed is accepted, and slot_start_o is 1 in the following cycle.
- R4: line_high_o falls in the same cycle that slot_start_o is 1. It stays 0 until line_i is sampled high, and returns to 1 in the cycle after that sample.
- R5: For HOLD_N samples after the sample at which line_i returned high, low samples are ignored at either speed, whatever their length inside that window.
- R6: A low level that extends past the hold-off window is qualified from the first sample after the window. At standard speed it starts a slot once FILT_N such samples have been seen. At overdrive speed a single sample suffices.
- R7: When a slot is accepted with rd_en_i = 1 and rd_bit_i = 0, pull_low_o is 1 starting in the strobe cycle. It stays 1 for PULL_STD cycles at standard speed and for PULL_OD cycles at overdrive speed, with the speed taken at the accept sample.
- R8: When a slot is accepted with rd_en_i = 0 or rd_bit_i = 1, pull_low_o stays 0.
- R9: A low level held for many cycles produces exactly one slot_start_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Synchronized bus level, 1 = high |
| overdrive_i | input | 1 | 1 selects overdrive speed |
| rd_en_i | input | 1 | Next accepted slot is a read slot |
| rd_bit_i | input | 1 | Bit to answer in a read slot |
| slot_start_o | output | 1 | One-cycle strobe at each accepted slot start |
| pull_low_o | output | 1 | Enable for the open-drain pull-down |
| line_high_o | output | 1 | Filtered bus state, 0 while inside a slot |

## Verification
The assertions assume that line_i is already synchronized and that overdrive_i only changes while the bus is idle. With those inputs, the run of low samples before a standard-speed strobe and the distance from the last rising edge can be measured directly. The bench models the wired bus as its own drive ANDed with the inverse of pull_low_o. It changes its drive and the speed only on falling clock edges, with long idle gaps between scenarios. It places glitches at exact sample offsets on both sides of the filter and hold-off limits, so every strobe count is predictable.

// File: rtl/owire_pkg.sv
package owire_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2
  } slot_state_e;
endpackage

// File: rtl/owire_fall_filter.sv
module owire_fall_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bypass_i,
  input  logic line_i,
  output logic accept_o
);
  generate
    if (FILT_N > 1) begin : g_cnt
      localparam int CW = $clog2(FILT_N);
      localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);
      logic [CW-1:0] low_cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                low_cnt_q <= '0;
        else if (!en_i || line_i)   low_cnt_q <= '0;
        else if (low_cnt_q != LAST) low_cnt_q <= low_cnt_q + 1'b1;
      end

      assign accept_o = en_i && !line_i && (bypass_i || (low_cnt_q == LAST));
    end else begin : g_direct
      logic unused_bypass;
      assign unused_bypass = bypass_i;
      assign accept_o = en_i && !line_i;
    end
  endgenerate
endmodule

// File: rtl/owire_holdoff.sv
module owire_holdoff #(
  parameter int HOLD_N = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int HW = (HOLD_N > 1) ? $clog2(HOLD_N) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD_N - 1);

  logic          active_q;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign done_o = active_q && (cnt_q == LAST);
endmodule

// File: rtl/owire_pull_timer.sv
module owire_pull_timer #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] len_i,
  output logic          pull_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_o <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pull_o <= 1'b1;
      cnt_q  <= len_i - 1'b1;
    end else if (pull_o) begin
      if (cnt_q == '0) pull_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/owire_slot_front.sv
module owire_slot_front #(
  parameter int FILT_N   = 4,
  parameter int HOLD_N   = 6,
  parameter int PULL_STD = 20,
  parameter int PULL_OD  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic overdrive_i,
  input  logic rd_en_i,
  input  logic rd_bit_i,
  output logic slot_start_o,
  output logic pull_low_o,
  output logic line_high_o
);
  import owire_pkg::*;

  localparam int PMAX = (PULL_STD > PULL_OD) ? PULL_STD : PULL_OD;
  localparam int PW   = $clog2(PMAX + 1);

  slot_state_e   state_q, state_d;
  logic          accept, rise, hold_done, pull_load;
  logic [PW-1:0] pull_len;

  owire_fall_filter #(.FILT_N(FILT_N)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_IDLE),
    .bypass_i (overdrive_i),
    .line_i   (line_i),
    .accept_o (accept)
  );

  // qualified rise: end of an accepted slot only
  assign rise = (state_q == ST_SLOT) && line_i;

  owire_holdoff #(.HOLD_N(HOLD_N)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rise),
    .done_o (hold_done)
  );

  assign pull_load = accept && rd_en_i && !rd_bit_i;
  assign pull_len  = overdrive_i ? PW'(PULL_OD) : PW'(PULL_STD);

  owire_pull_timer #(.PW(PW)) u_pull (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pull_load),
    .len_i  (pull_len),
    .pull_o (pull_low_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_SLOT;
      ST_SLOT: if (rise)      state_d = ST_HOLD;
      ST_HOLD: if (hold_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      slot_start_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      slot_start_o <= accept;
    end
  end

  assign line_high_o = (state_q != ST_SLOT);
endmodule

// File: rtl/owire_slot_front_chk.sv
module owire_slot_front_chk #(
  parameter int FILT_N   = 4,
  parameter int HOLD_N   = 6,
  parameter int PULL_STD = 20,
  parameter int PULL_OD  = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic overdrive_i,
  input logic slot_start_o,
  input logic pull_low_o,
  input logic line_high_o
);
  localparam int CW   = $clog2(FILT_N + HOLD_N + PULL_STD + PULL_OD + 4) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] low_run_q, since_rise_q, pull_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q    <= '0;
      since_rise_q <= CMAX;
      pull_run_q   <= '0;
    end else begin
      low_run_q    <= line_i ? '0 : ((low_run_q == CMAX) ? CMAX : low_run_q + 1'b1);
      since_rise_q <= !line_high_o ? '0 :
                      ((since_rise_q == CMAX) ? CMAX : since_rise_q + 1'b1);
      pull_run_q   <= !pull_low_o ? '0 : ((pull_run_q == CMAX) ? CMAX : pull_run_q + 1'b1);
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!slot_start_o && !pull_low_o && line_high_o));

  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> !slot_start_o);

  a_r2_filtered_low_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_o && !$past(overdrive_i)) |-> (low_run_q >= CW'(FILT_N)));

  a_r3_low_before_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> !$past(line_i));

  a_r4_state_falls_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_high_o) |-> slot_start_o);

  a_r5_holdoff_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> (since_rise_q >= CW'(HOLD_N + 1)));

  a_r7_pull_starts_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) |-> slot_start_o);

  a_r7_pull_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_low_o |-> (pull_run_q < CW'(PULL_STD > PULL_OD ? PULL_STD : PULL_OD)));

  a_r7_pull_inside_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_low_o |-> !line_high_o);
endmodule

bind owire_slot_front owire_slot_front_chk #(
  .FILT_N(FILT_N), .HOLD_N(HOLD_N), .PULL_STD(PULL_STD), .PULL_OD(PULL_OD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .overdrive_i (overdrive_i),
  .slot_start_o(slot_start_o),
  .pull_low_o  (pull_low_o),
  .line_high_o (line_high_o)
);

// File: tb/owire_slot_front_tb.sv
module owire_slot_front_tb;
  localparam int FILT_N   = 4;
  localparam int HOLD_N   = 6;
  localparam int PULL_STD = 20;
  localparam int PULL_OD  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic drv = 1'b1;
  logic overdrive = 1'b0, rd_en = 1'b0, rd_bit = 1'b1;
  logic slot_start, pull_low, line_high, line;
  int   n_tests = 0, n_fail = 0, strobes = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign line = drv & ~pull_low;

  owire_slot_front #(
    .FILT_N(FILT_N), .HOLD_N(HOLD_N), .PULL_STD(PULL_STD), .PULL_OD(PULL_OD)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .overdrive_i(overdrive),
    .rd_en_i(rd_en), .rd_bit_i(rd_bit),
    .slot_start_o(slot_start), .pull_low_o(pull_low), .line_high_o(line_high)
  );

  always @(negedge clk) if (rst_ni && slot_start) strobes++;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    drv = 1'b1;
    repeat (HOLD_N + FILT_N + PULL_STD + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 strobe", slot_start, 0);
    check("R1 pull", pull_low, 0);
    check("R1 line_high", line_high, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 strobe after release", slot_start, 0);
    check("R1 line_high after release", line_high, 1);
  endtask

  // low pulse of len samples from idle; exp_n strobes
  task automatic t_pulse(string tag, bit od, int len, int exp_n);
    int s0;
    settle();
    overdrive = od;
    @(negedge clk);
    s0 = strobes;
    drv = 1'b0;
    repeat (len) @(negedge clk);
    drv = 1'b1;
    settle();
    check(tag, strobes - s0, exp_n);
  endtask

  task automatic t_timing();
    settle();
    overdrive = 1'b0;
    drv = 1'b0;
    repeat (FILT_N - 1) @(negedge clk);
    check("R2 no strobe before FILT_N samples", slot_start, 0);
    @(negedge clk);
    check("R2 strobe after FILT_N samples", slot_start, 1);
    check("R4 line_high low with strobe", line_high, 0);
    @(negedge clk);
    check("R2 strobe one cycle", slot_start, 0);
    drv = 1'b1;
    @(negedge clk);
    check("R4 line_high back high", line_high, 1);
    settle();
    overdrive = 1'b1;
    drv = 1'b0;
    @(negedge clk);
    check("R3 overdrive strobe after one sample", slot_start, 1);
    drv = 1'b1;
    settle();
    overdrive = 1'b0;
  endtask

  // slot, then glitch starting d samples after the rise, w samples long
  task automatic t_glitch(string tag, bit od, int d, int w, int exp_extra);
    int s0;
    settle();
    overdrive = od;
    @(negedge clk);
    s0 = strobes;
    drv = 1'b0;
    repeat (FILT_N + 1) @(negedge clk);
    drv = 1'b1;
    repeat (d) @(negedge clk);
    drv = 1'b0;
    repeat (w) @(negedge clk);
    drv = 1'b1;
    settle();
    check(tag, strobes - s0, 1 + exp_extra);
  endtask

  task automatic t_read(string tag, bit od, bit en, bit bitv, int exp_len);
    int cnt = 0;
    settle();
    overdrive = od;
    rd_en = en;
    rd_bit = bitv;
    @(negedge clk);
    drv = 1'b0;
    repeat (od ? 1 : FILT_N) @(negedge clk);
    drv = 1'b1;
    rd_en = 1'b0;
    for (int i = 0; i < PULL_STD + 10; i++) begin
      if (pull_low) cnt++;
      @(negedge clk);
    end
    check(tag, cnt, exp_len);
    check({tag, " line_high after"}, line_high, 1);
    overdrive = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_timing();
    t_pulse("R2 short pulse rejected", 1'b0, FILT_N - 1, 0);
    t_pulse("R2 pulse of FILT_N accepted", 1'b0, FILT_N, 1);
    t_pulse("R3 single sample at overdrive", 1'b1, 1, 1);
    t_pulse("R9 long low one strobe", 1'b0, 40, 1);
    t_glitch("R5 short glitch in holdoff", 1'b0, 2, 3, 0);
    t_glitch("R5 overdrive glitch at last holdoff sample", 1'b1, HOLD_N, 1, 0);
    t_glitch("R6 overdrive glitch after holdoff", 1'b1, HOLD_N + 1, 1, 1);
    t_glitch("R6 long low spans holdoff by FILT_N", 1'b0, 2, HOLD_N - 1 + FILT_N, 1);
    t_glitch("R6 long low spans holdoff by FILT_N-1", 1'b0, 2, HOLD_N - 2 + FILT_N, 0);
    t_read("R7 read zero standard", 1'b0, 1'b1, 1'b0, PULL_STD);
    t_read("R7 read zero overdrive", 1'b1, 1'b1, 1'b0, PULL_OD);
    t_read("R8 read one no pull", 1'b0, 1'b1, 1'b1, 0);
    t_read("R8 no read no pull", 1'b1, 1'b0, 1'b0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule